// File: doc/BRIEF.md
# Hierarchical Address Route Selector

This block decides where one network endpoint sends an incoming command. Each command carries a 32-bit request flag word and a target address spread over three packed 16-bit halfwords: an on-chip grid position, a chip position inside the chassis, and a rack and shelf position. The block compares that six-coordinate target with the endpoint's own configured coordinates. It then picks one of four destinations: execute locally, on-chip network 0, on-chip network 1, or a neighbouring link port.

Which link port reaches which chip is held in a small reachability table that configuration writes one port row at a time. When no port reaches the target, the block returns an error response word instead of a route. A command whose operation bits are malformed is rejected outright. The decision takes one clock: every accepted command produces exactly one registered result on the next cycle.

Top module: `route_sel`

## Requirements
- R1: After synchronous reset, rsp_valid, route_code, port_idx and rsp_flags are all zero, and every reachability table row is empty.
- R2: A result appears exactly one clock after each command: rsp_valid is high in the cycle after req_valid was high, and low in the cycle after req_valid was low.
- R3: Coordinates are taken from fixed field positions. Grid halfword: bits 3:0 are ignored, X is bits 9:4 and Y is bits 15:10. Chip halfword: X is bits 5:0, Y is bits 11:6, and bits 15:12 are ignored. Rack halfword: rack is bits 7:0 and shelf is bits 15:8.
- R4: When all six target coordinates equal the own coordinates, route_code is 0 (local), port_idx is 0 and rsp_flags is 0.
- R5: When chip, rack and shelf match but the grid position differs, route_code is 1 (network 0). When request flag bit 9 is set, route_code is 2 (network 1). In both cases port_idx and rsp_flags are 0.
- R6: When rack and shelf match but the chip position differs, the command goes to a link port, with route_code 3 and rsp_flags 0. The lookup uses table slot Y*CHIP_XS+X, and port_idx is the lowest-numbered port whose row has that slot's bit set.
- R7: A target is unreachable if its rack or shelf differs from the own values, if its chip X or Y falls outside the table range, or if no port row has its slot bit set. An unreachable target gives route_code 4, port_idx 0, and rsp_flags 0x80000008 for a read or 0x80000002 for a write. Bit 31 is the unreachable flag, bit 3 is read-data and bit 1 is write-ack.
- R8: Request flag bit 0 marks a write and bit 2 marks a read. A command with neither bit set, or with both set, gives route_code 5 and rsp_flags 0x80000000, whatever its address.
- R9: A pulse on cfg_we replaces the whole row for port cfg_port with cfg_reach and leaves the other rows unchanged. Request flag bits other than 0, 2 and 9 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_grid_x | input | 6 | Own on-chip grid X |
| own_grid_y | input | 6 | Own on-chip grid Y |
| own_chip_x | input | 6 | Own chip X in chassis |
| own_chip_y | input | 6 | Own chip Y in chassis |
| own_rack | input | 8 | Own rack number |
| own_shelf | input | 8 | Own shelf number |
| cfg_we | input | 1 | Write one reachability row |
| cfg_port | input | PORT_W | Row (link port) to write |
| cfg_reach | input | CHIP_XS*CHIP_YS | Reachable chip slot bitmap for that port |
| req_valid | input | 1 | Command present |
| req_flags | input | 32 | Request flag word |
| req_grid | input | 16 | Packed grid coordinate halfword |
| req_chip | input | 16 | Packed chip coordinate halfword |
| req_rack | input | 16 | Packed rack/shelf halfword |
| rsp_valid | output | 1 | Result present |
| route_code | output | 3 | 0 local, 1 network 0, 2 network 1, 3 link, 4 unreachable, 5 rejected |
| port_idx | output | PORT_W | Chosen link port |
| rsp_flags | output | 32 | Response flag word |

## Verification
Every result is due on the first rising edge after its command is presented. Reachability rows written with cfg_we take effect at that same edge, so a command in any later cycle already sees them. The bench changes inputs on the falling edge and pushes the expected result into a queue at that point. The monitor pops the queue on the next falling edge whenever rsp_valid is high, so each comparison sees exactly one register stage. At the end the bench also requires that rsp_valid never appears without a queued item and that no item is left unmatched.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;

    localparam int GRID_W = 6;
    localparam int CHIP_W = 6;
    localparam int RACK_W = 8;

    // request flag bit positions
    localparam int FL_WRITE = 0;
    localparam int FL_READ  = 2;
    localparam int FL_NOC1  = 9;

    // response flag bit positions
    localparam int RS_WACK    = 1;
    localparam int RS_RDATA   = 3;
    localparam int RS_UNREACH = 31;

    typedef enum logic [2:0] {
        RT_LOCAL   = 3'd0,
        RT_NOC0    = 3'd1,
        RT_NOC1    = 3'd2,
        RT_LINK    = 3'd3,
        RT_UNREACH = 3'd4,
        RT_REJECT  = 3'd5
    } route_e;

    typedef enum logic [1:0] {
        OP_BAD   = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef struct packed {
        logic [GRID_W-1:0] gx;
        logic [GRID_W-1:0] gy;
        logic [CHIP_W-1:0] cx;
        logic [CHIP_W-1:0] cy;
        logic [RACK_W-1:0] rack;
        logic [RACK_W-1:0] shelf;
    } coord_t;

    function automatic coord_t unpack_coord(input logic [15:0] grid,
                                            input logic [15:0] chip,
                                            input logic [15:0] rk);
        coord_t c;
        c.gx    = grid[9:4];
        c.gy    = grid[15:10];
        c.cx    = chip[5:0];
        c.cy    = chip[11:6];
        c.rack  = rk[7:0];
        c.shelf = rk[15:8];
        return c;
    endfunction

    function automatic op_e classify_op(input logic [31:0] flags);
        case ({flags[FL_READ], flags[FL_WRITE]})
            2'b01:   return OP_WRITE;
            2'b10:   return OP_READ;
            default: return OP_BAD;
        endcase
    endfunction

    function automatic logic [31:0] unreach_word(input op_e op);
        logic [31:0] w;
        w = '0;
        w[RS_UNREACH] = 1'b1;
        if (op == OP_READ)  w[RS_RDATA] = 1'b1;
        if (op == OP_WRITE) w[RS_WACK]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/route_sel_decode.sv
module route_sel_decode
    import route_sel_pkg::*;
(
    input  logic [31:0] flags,
    input  logic [15:0] grid,
    input  logic [15:0] chip,
    input  logic [15:0] rk,
    output coord_t      tgt,
    output op_e         op,
    output logic        use_noc1
);
    logic unused_bits;

    assign tgt      = unpack_coord(grid, chip, rk);
    assign op       = classify_op(flags);
    assign use_noc1 = flags[FL_NOC1];
    assign unused_bits = ^{grid[3:0], chip[15:12], flags};
endmodule

// File: rtl/route_sel_reach.sv
module route_sel_reach #(
    parameter int NUM_PORTS = 4,
    parameter int CHIP_XS   = 4,
    parameter int CHIP_YS   = 4,
    localparam int SLOTS    = CHIP_XS * CHIP_YS,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [SLOTS-1:0]  cfg_reach,
    input  logic [5:0]        look_x,
    input  logic [5:0]        look_y,
    output logic              hit,
    output logic [PORT_W-1:0] hit_port
);
    logic [SLOTS-1:0]     rows [NUM_PORTS];
    logic [NUM_PORTS-1:0] col;
    logic                 in_range;
    logic [SLOT_W-1:0]    slot;

    assign in_range = (int'(look_x) < CHIP_XS) && (int'(look_y) < CHIP_YS);

    always_comb begin
        int s;
        s = int'(look_y) * CHIP_XS + int'(look_x);
        slot = in_range ? SLOT_W'(s) : '0;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst)
                    rows[p] <= '0;
                else if (cfg_we && int'(cfg_port) == p)
                    rows[p] <= cfg_reach;
            end
            assign col[p] = in_range && rows[p][slot];
        end
    endgenerate

    always_comb begin
        hit      = |col;
        hit_port = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (col[p]) hit_port = PORT_W'(p);
        end
    end
endmodule

// File: rtl/route_sel_decide.sv
module route_sel_decide
    import route_sel_pkg::*;
#(
    parameter int PORT_W = 2
) (
    input  coord_t            tgt,
    input  coord_t            own,
    input  op_e               op,
    input  logic              use_noc1,
    input  logic              hit,
    input  logic [PORT_W-1:0] hit_port,
    output route_e            route,
    output logic [PORT_W-1:0] port,
    output logic [31:0]       flags,
    output logic              rack_ok
);
    logic grid_eq;
    logic chip_eq;

    assign grid_eq = (tgt.gx == own.gx) && (tgt.gy == own.gy);
    assign chip_eq = (tgt.cx == own.cx) && (tgt.cy == own.cy);
    assign rack_ok = (tgt.rack == own.rack) && (tgt.shelf == own.shelf);

    always_comb begin
        route = RT_LOCAL;
        port  = '0;
        flags = '0;
        if (op == OP_BAD) begin
            route = RT_REJECT;
            flags[RS_UNREACH] = 1'b1;
        end else if (rack_ok && chip_eq) begin
            if (grid_eq)       route = RT_LOCAL;
            else if (use_noc1) route = RT_NOC1;
            else               route = RT_NOC0;
        end else if (rack_ok && hit) begin
            route = RT_LINK;
            port  = hit_port;
        end else begin
            route = RT_UNREACH;
            flags = unreach_word(op);
        end
    end
endmodule

// File: rtl/route_sel.sv
module route_sel
    import route_sel_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CHIP_XS   = 4,
    parameter int CHIP_YS   = 4,
    localparam int SLOTS    = CHIP_XS * CHIP_YS,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        own_grid_x,
    input  logic [5:0]        own_grid_y,
    input  logic [5:0]        own_chip_x,
    input  logic [5:0]        own_chip_y,
    input  logic [7:0]        own_rack,
    input  logic [7:0]        own_shelf,
    input  logic              cfg_we,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic [SLOTS-1:0]  cfg_reach,
    input  logic              req_valid,
    input  logic [31:0]       req_flags,
    input  logic [15:0]       req_grid,
    input  logic [15:0]       req_chip,
    input  logic [15:0]       req_rack,
    output logic              rsp_valid,
    output logic [2:0]        route_code,
    output logic [PORT_W-1:0] port_idx,
    output logic [31:0]       rsp_flags
);
    coord_t            tgt;
    coord_t            own;
    op_e               op;
    logic              use_noc1;
    logic              hit;
    logic [PORT_W-1:0] hit_port;
    route_e            route_nx;
    logic [PORT_W-1:0] port_nx;
    logic [31:0]       flags_nx;
    logic              rack_ok_unused;

    assign own = '{gx: own_grid_x, gy: own_grid_y, cx: own_chip_x,
                   cy: own_chip_y, rack: own_rack, shelf: own_shelf};

    route_sel_decode u_decode (
        .flags    (req_flags),
        .grid     (req_grid),
        .chip     (req_chip),
        .rk       (req_rack),
        .tgt      (tgt),
        .op       (op),
        .use_noc1 (use_noc1)
    );

    route_sel_reach #(
        .NUM_PORTS (NUM_PORTS),
        .CHIP_XS   (CHIP_XS),
        .CHIP_YS   (CHIP_YS)
    ) u_reach (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_reach (cfg_reach),
        .look_x    (tgt.cx),
        .look_y    (tgt.cy),
        .hit       (hit),
        .hit_port  (hit_port)
    );

    route_sel_decide #(
        .PORT_W (PORT_W)
    ) u_decide (
        .tgt      (tgt),
        .own      (own),
        .op       (op),
        .use_noc1 (use_noc1),
        .hit      (hit),
        .hit_port (hit_port),
        .route    (route_nx),
        .port     (port_nx),
        .flags    (flags_nx),
        .rack_ok  (rack_ok_unused)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            route_code <= '0;
            port_idx   <= '0;
            rsp_flags  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                route_code <= route_nx;
                port_idx   <= port_nx;
                rsp_flags  <= flags_nx;
            end
        end
    end
endmodule

// File: rtl/route_sel_chk.sv
module route_sel_chk #(
    parameter int PORT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [31:0]       req_flags,
    input logic              rsp_valid,
    input logic [2:0]        route_code,
    input logic [PORT_W-1:0] port_idx,
    input logic [31:0]       rsp_flags
);
    // R2: one result per command, one cycle later
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: malformed operation bits are rejected
    p_bad_op_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_flags[0] == req_flags[2]))
        |=> (route_code == 3'd5 && rsp_flags == 32'h8000_0000));

    // R5: network 1 only when the request asked for it
    p_noc1_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && route_code == 3'd2) |-> $past(req_flags[9]));

    // R4: successful routes carry no response flags
    p_clean_ok_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && route_code <= 3'd3) |-> (rsp_flags == 32'h0));

    // R7: unreachable word has the error bit plus exactly one operation bit
    p_unreach_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && route_code == 3'd4)
        |-> (rsp_flags[31] && $countones(rsp_flags) == 2 &&
             $onehot(rsp_flags[3:0] & 4'b1010)));

    // R6: a port index is only given for link routes
    p_port_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && route_code != 3'd3) |-> (port_idx == '0));
endmodule

bind route_sel route_sel_chk #(.PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_flags  (req_flags),
    .rsp_valid  (rsp_valid),
    .route_code (route_code),
    .port_idx   (port_idx),
    .rsp_flags  (rsp_flags)
);

// File: tb/route_sel_tb.sv
module route_sel_tb;
    localparam int NP = 4;
    localparam int XS = 4;
    localparam int YS = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    own_grid_x = 6'd3, own_grid_y = 6'd5;
    logic [5:0]    own_chip_x = 6'd1, own_chip_y = 6'd0;
    logic [7:0]    own_rack = 8'd2, own_shelf = 8'd1;
    logic          cfg_we = 1'b0;
    logic [PW-1:0] cfg_port = '0;
    logic [XS*YS-1:0] cfg_reach = '0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_flags = '0;
    logic [15:0]   req_grid = '0, req_chip = '0, req_rack = '0;
    logic          rsp_valid;
    logic [2:0]    route_code;
    logic [PW-1:0] port_idx;
    logic [31:0]   rsp_flags;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]    code;
        logic [PW-1:0] port;
        logic [31:0]   flags;
        string         tag;
    } exp_t;

    exp_t q[$];
    logic [XS*YS-1:0] tab [NP];

    always #5 clk = ~clk;

    route_sel u_dut (.*);

    function automatic logic [15:0] mk_grid(int x, int y, int junk);
        return 16'((y << 10) | (x << 4) | (junk & 15));
    endfunction
    function automatic logic [15:0] mk_chip(int x, int y, int junk);
        return 16'(((junk & 15) << 12) | (y << 6) | x);
    endfunction
    function automatic logic [15:0] mk_rack(int r, int s);
        return 16'((s << 8) | r);
    endfunction

    // bench-side model written from the requirements
    function automatic exp_t model(logic [31:0] f, logic [15:0] g,
                                   logic [15:0] c, logic [15:0] r, string tag);
        exp_t e;
        int cx, cy, s;
        e.tag = tag; e.port = '0; e.flags = '0; e.code = 3'd0;
        cx = int'(c[5:0]); cy = int'(c[11:6]);
        if (f[0] == f[2]) begin
            e.code = 3'd5; e.flags = 32'h8000_0000; return e;
        end
        if (r[7:0] == own_rack && r[15:8] == own_shelf &&
            c[5:0] == own_chip_x && c[11:6] == own_chip_y) begin
            if (g[9:4] == own_grid_x && g[15:10] == own_grid_y) e.code = 3'd0;
            else e.code = f[9] ? 3'd2 : 3'd1;
            return e;
        end
        if (r[7:0] == own_rack && r[15:8] == own_shelf && cx < XS && cy < YS) begin
            s = cy * XS + cx;
            for (int p = NP - 1; p >= 0; p--)
                if (tab[p][s]) begin e.code = 3'd3; e.port = PW'(p); end
            if (e.code == 3'd3) return e;
        end
        e.code = 3'd4;
        e.flags = f[2] ? 32'h8000_0008 : 32'h8000_0002;
        return e;
    endfunction

    task automatic load_row(int p, logic [XS*YS-1:0] v);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_port = PW'(p); cfg_reach = v;
        tab[p] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(logic [31:0] f, logic [15:0] g, logic [15:0] c,
                        logic [15:0] r, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_flags = f; req_grid = g; req_chip = c; req_rack = r;
        q.push_back(model(f, g, c, r, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [XS*YS-1:0] slot_bit(int x, int y);
        logic [XS*YS-1:0] v;
        v = '0; v[y * XS + x] = 1'b1;
        return v;
    endfunction

    // monitor: compares results one register stage after the command
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected result: got rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (route_code !== e.code || port_idx !== e.port || rsp_flags !== e.flags) begin
                    bad++;
                    $display("FAIL %s: got code=%0d port=%0d flags=%h expected code=%0d port=%0d flags=%h",
                             e.tag, route_code, port_idx, rsp_flags, e.code, e.port, e.flags);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] RD = 32'h4;
    localparam logic [31:0] WR = 32'h1;

    initial begin
        logic [15:0] home;
        for (int p = 0; p < NP; p++) tab[p] = '0;
        home = mk_rack(2, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        total++;
        if (rsp_valid !== 1'b0 || route_code !== 3'd0 || port_idx !== '0 || rsp_flags !== '0) begin
            bad++;
            $display("FAIL R1 reset: got v=%b code=%0d port=%0d flags=%h expected all zero",
                     rsp_valid, route_code, port_idx, rsp_flags);
        end
        // R1: empty table after reset makes a remote chip unreachable
        send(RD, mk_grid(3, 5, 0), mk_chip(0, 0, 0), home, "R1 empty table");
        idle();
        // R4 local, R3 ignored low/high bits
        send(RD, mk_grid(3, 5, 0), mk_chip(1, 0, 0), home, "R4 local read");
        send(WR, mk_grid(3, 5, 9), mk_chip(1, 0, 7), home, "R3 ignored field bits local");
        // R5 network selection
        send(RD, mk_grid(4, 5, 0), mk_chip(1, 0, 0), home, "R5 network 0");
        send(WR | 32'h200, mk_grid(3, 6, 0), mk_chip(1, 0, 0), home, "R5 network 1");
        // R9 other flag bits ignored
        send(RD | 32'h14D0, mk_grid(3, 5, 0), mk_chip(1, 0, 0), home, "R9 extra flags local");
        // R8 malformed ops
        send(32'h0, mk_grid(3, 5, 0), mk_chip(1, 0, 0), home, "R8 no op bit");
        send(32'h5, mk_grid(9, 9, 0), mk_chip(3, 3, 0), mk_rack(7, 7), "R8 both op bits");
        idle();
        // load table rows (R9)
        load_row(1, slot_bit(0, 0) | slot_bit(2, 1));
        load_row(2, slot_bit(0, 0) | slot_bit(3, 3));
        load_row(3, slot_bit(2, 1));
        // R6 link lookups with lowest port priority
        send(RD, mk_grid(0, 0, 0), mk_chip(0, 0, 0), home, "R6 slot 0 lowest port");
        send(WR, mk_grid(1, 1, 0), mk_chip(2, 1, 0), home, "R6 slot 6 lowest port");
        send(RD | 32'h200, mk_grid(3, 5, 0), mk_chip(3, 3, 0), home, "R6 slot 15 port 2");
        // R3 rack/shelf byte order: swapped bytes differ
        send(RD, mk_grid(3, 5, 0), mk_chip(1, 0, 0), mk_rack(1, 2), "R3 rack shelf order");
        // R7 unreachable cases
        send(RD, mk_grid(3, 5, 0), mk_chip(1, 1, 0), home, "R7 no port read");
        send(WR, mk_grid(3, 5, 0), mk_chip(1, 1, 0), home, "R7 no port write");
        send(RD, mk_grid(3, 5, 0), mk_chip(5, 0, 0), home, "R7 x out of range");
        send(WR, mk_grid(3, 5, 0), mk_chip(0, 0, 0), mk_rack(2, 0), "R7 shelf differs");
        idle();
        // R9 reload row 0 takes priority; other rows untouched
        load_row(0, slot_bit(2, 1));
        send(RD, mk_grid(0, 0, 0), mk_chip(2, 1, 0), home, "R9 reload row 0");
        send(RD, mk_grid(0, 0, 0), mk_chip(3, 3, 0), home, "R9 row 2 kept");
        // R9 clearing a row
        load_row(2, '0);
        send(WR, mk_grid(0, 0, 0), mk_chip(3, 3, 0), home, "R9 row 2 cleared");
        idle();
        idle();
        // R2: no result pending after idle cycles
        total++;
        if (q.size() != 0 || rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R2 drain: got pending=%0d valid=%b expected 0 0", q.size(), rsp_valid);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule